// File: doc/BRIEF.md
# High-Bandwidth Isochronous IN Micro-Frame Checker

This block watches one high-bandwidth isochronous IN endpoint across each micro-frame. During a micro-frame it counts the banks that the CPU validates and the IN tokens that arrive from the host. It also remembers whether any packet went out to the host. When the next micro-frame start strobe arrives, it compares both counts with the configured number of transactions per micro-frame.

A bank shortfall sets a sticky error flag and, unless the shortfall comes from a missing token, a one-cycle underflow pulse. That pulse asks the packet engine to send a zero-length packet. Missing IN tokens set a sticky flush flag and produce a one-cycle flush request, so that the banks meant for that micro-frame are discarded and host and device stay aligned.

Both flags stay set until the CPU clears them with a write-one-to-clear strobe. Each flag drives the endpoint interrupt through its own enable bit. The checker does not store bank data and does not handle bus signalling.

Top module: `hbiso_mframe_chk`

## Requirements
- R1: After reset, err_flag_o, flush_flag_o, flush_req_o, underflow_o and irq_o are all 0.
- R2: At a micro-frame boundary (a cycle with sof_i=1), if at least one packet was sent in the micro-frame that is ending and fewer banks were validated than ntrans_i, err_flag_o reads 1 from the cycle after the boundary.
- R3: If no packet was sent during the micro-frame that is ending, the boundary sets no flag and produces no pulse.
- R4: If fewer IN tokens arrived than ntrans_i in an evaluated micro-frame, flush_flag_o reads 1 from the cycle after the boundary, and flush_req_o is 1 in exactly that one cycle.
- R5: A bank shortfall also gives a one-cycle underflow_o pulse in the cycle after the boundary, unless IN tokens were missing in the same micro-frame. In that case underflow_o stays 0.
- R6: No evaluation happens when ntrans_i is 0 (the legal values are 1 to 3), when feat_en_i is 0, or when ep_hbiso_in_i is 0.
- R7: The bank count, the token count and the packet-sent record restart at every boundary. Strobes that occur in the boundary cycle count toward the new micro-frame.
- R8: Both flags are sticky until their clear strobe (err_clr_i, flush_clr_i) is 1. If a set and a clear occur in the same cycle, the set wins.
- R9: irq_o is 1 exactly when (err_flag_o and err_ie_i) or (flush_flag_o and flush_ie_i).
- R10: Counts at or above ntrans_i raise nothing. The counters saturate, so extra strobes cause no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Micro-frame start strobe; marks the boundary |
| in_tok_i | input | 1 | IN token received strobe |
| pkt_sent_i | input | 1 | Packet sent to host strobe |
| bank_val_i | input | 1 | CPU validated a bank strobe |
| ntrans_i | input | 2 | Transactions per micro-frame (0 disables the checks) |
| feat_en_i | input | 1 | High-bandwidth feature present |
| ep_hbiso_in_i | input | 1 | Endpoint is configured as high-bandwidth isochronous IN |
| err_ie_i | input | 1 | Interrupt enable for the error flag |
| flush_ie_i | input | 1 | Interrupt enable for the flush flag |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| flush_clr_i | input | 1 | Write-one-to-clear strobe for the flush flag |
| err_flag_o | output | 1 | Sticky bank-shortfall error flag |
| flush_flag_o | output | 1 | Sticky missing-token flush flag |
| flush_req_o | output | 1 | One-cycle request to flush this micro-frame's banks |
| underflow_o | output | 1 | One-cycle underflow pulse (zero-length packet request) |
| irq_o | output | 1 | Endpoint interrupt |

## Verification
The hardest case to reach is a boundary at which both a bank shortfall and a token shortfall occur. Here the error flag must rise while the underflow pulse is held back.

A related case is a boundary cycle that carries strobes of its own, which must count toward the new micro-frame and not the old one.

The bench reaches both cases with a frame task that sets the bank, token and packet counts independently. A second argument of the same task drives bank-validate and IN-token strobes in the same cycle as the start strobe. The following frame then depends on those carried-over counts to avoid any flag.

// File: rtl/hbiso_pkg.sv
package hbiso_pkg;
    typedef struct packed {
        logic err;        // sticky bank-shortfall flag
        logic flush;      // sticky missing-token flag
        logic flush_req;  // one-cycle flush request
        logic unf;        // one-cycle underflow pulse
        logic sent_any;   // a packet went out this micro-frame
    } chk_st_t;
endpackage

// File: rtl/hbiso_ev_counter.sv
module hbiso_ev_counter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = inc ? W'(1) : '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && inc && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + W'(1));

    // R10
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/hbiso_frame_eval.sv
module hbiso_frame_eval #(
    parameter int W = 2
) (
    input  logic [W-1:0] ntrans,
    input  logic [W-1:0] bank_cnt,
    input  logic [W-1:0] tok_cnt,
    input  logic         armed,
    output logic         short_o,
    output logic         miss_o
);
    logic active;

    always_comb begin
        active  = armed && (ntrans != '0);
        short_o = active && (bank_cnt < ntrans);
        miss_o  = active && (tok_cnt < ntrans);
    end
endmodule

// File: rtl/hbiso_mframe_chk.sv
module hbiso_mframe_chk
    import hbiso_pkg::*;
#(
    parameter int NTRANS_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof_i,
    input  logic                in_tok_i,
    input  logic                pkt_sent_i,
    input  logic                bank_val_i,
    input  logic [NTRANS_W-1:0] ntrans_i,
    input  logic                feat_en_i,
    input  logic                ep_hbiso_in_i,
    input  logic                err_ie_i,
    input  logic                flush_ie_i,
    input  logic                err_clr_i,
    input  logic                flush_clr_i,
    output logic                err_flag_o,
    output logic                flush_flag_o,
    output logic                flush_req_o,
    output logic                underflow_o,
    output logic                irq_o
);
    localparam int CNT_W = NTRANS_W;

    chk_st_t st_d, st_q;
    logic [CNT_W-1:0] bank_cnt, tok_cnt;
    logic short_w, miss_w, armed_w;

    hbiso_ev_counter #(.W(CNT_W)) u_bank_cnt (
        .clk(clk), .rst_n(rst_n), .restart(sof_i), .inc(bank_val_i), .cnt_o(bank_cnt)
    );

    hbiso_ev_counter #(.W(CNT_W)) u_tok_cnt (
        .clk(clk), .rst_n(rst_n), .restart(sof_i), .inc(in_tok_i), .cnt_o(tok_cnt)
    );

    assign armed_w = feat_en_i && ep_hbiso_in_i && st_q.sent_any;

    hbiso_frame_eval #(.W(CNT_W)) u_eval (
        .ntrans(ntrans_i), .bank_cnt(bank_cnt), .tok_cnt(tok_cnt),
        .armed(armed_w), .short_o(short_w), .miss_o(miss_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.flush_req = 1'b0;
        st_d.unf       = 1'b0;
        if (err_clr_i)   st_d.err   = 1'b0;
        if (flush_clr_i) st_d.flush = 1'b0;
        if (pkt_sent_i)  st_d.sent_any = 1'b1;
        if (sof_i) begin
            st_d.sent_any = pkt_sent_i;
            if (short_w) begin
                st_d.err = 1'b1;
                st_d.unf = !miss_w;
            end
            if (miss_w) begin
                st_d.flush     = 1'b1;
                st_d.flush_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_flag_o   = st_q.err;
    assign flush_flag_o = st_q.flush;
    assign flush_req_o  = st_q.flush_req;
    assign underflow_o  = st_q.unf;
    assign irq_o        = (st_q.err & err_ie_i) | (st_q.flush & flush_ie_i);

    // R4
    flush_after_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> $past(sof_i));

    // R4
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |=> !flush_req_o);

    // R5
    unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(underflow_o && flush_req_o));

    // R2
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> $past(sof_i));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag_o && !err_clr_i) |=> err_flag_o);

    // R8
    flush_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_flag_o && !flush_clr_i) |=> flush_flag_o);
endmodule

// File: tb/sim_hbiso_mframe_chk.sv
module sim_hbiso_mframe_chk;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_i = 0, in_tok_i = 0, pkt_sent_i = 0, bank_val_i = 0;
    logic [1:0] ntrans_i = 2'd3;
    logic feat_en_i = 1, ep_hbiso_in_i = 1, err_ie_i = 0, flush_ie_i = 0;
    logic err_clr_i = 0, flush_clr_i = 0;
    logic err_flag_o, flush_flag_o, flush_req_o, underflow_o, irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;  // 125 MHz

    hbiso_mframe_chk u0 (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .in_tok_i(in_tok_i),
        .pkt_sent_i(pkt_sent_i), .bank_val_i(bank_val_i), .ntrans_i(ntrans_i),
        .feat_en_i(feat_en_i), .ep_hbiso_in_i(ep_hbiso_in_i),
        .err_ie_i(err_ie_i), .flush_ie_i(flush_ie_i),
        .err_clr_i(err_clr_i), .flush_clr_i(flush_clr_i),
        .err_flag_o(err_flag_o), .flush_flag_o(flush_flag_o),
        .flush_req_o(flush_req_o), .underflow_o(underflow_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk); err_clr_i = 1; flush_clr_i = 1;
        @(negedge clk); err_clr_i = 0; flush_clr_i = 0;
    endtask

    // Drive one micro-frame, then a boundary; carry adds bank+token strobes in the boundary cycle.
    task automatic frame(input int nb, input int nt, input int ns, input bit carry);
        for (int i = 0; i < nb; i++) begin @(negedge clk); bank_val_i = 1; @(negedge clk); bank_val_i = 0; end
        for (int i = 0; i < nt; i++) begin @(negedge clk); in_tok_i = 1;   @(negedge clk); in_tok_i = 0;   end
        for (int i = 0; i < ns; i++) begin @(negedge clk); pkt_sent_i = 1; @(negedge clk); pkt_sent_i = 0; end
        @(negedge clk);
        sof_i = 1;
        if (carry) begin bank_val_i = 1; in_tok_i = 1; end
        @(negedge clk);
        sof_i = 0; bank_val_i = 0; in_tok_i = 0;
    endtask

    task automatic t_reset();
        check("R1 err", err_flag_o, 0);
        check("R1 flush", flush_flag_o, 0);
        check("R1 freq", flush_req_o, 0);
        check("R1 unf", underflow_o, 0);
        check("R1 irq", irq_o, 0);
    endtask

    task automatic t_bank_short();
        ntrans_i = 3; clear_flags();
        frame(2, 3, 1, 0);
        check("R2 err", err_flag_o, 1);
        check("R5 unf", underflow_o, 1);
        check("R4 no flush", flush_flag_o, 0);
        @(negedge clk);
        check("R5 unf single", underflow_o, 0);
    endtask

    task automatic t_tok_miss();
        ntrans_i = 3; clear_flags();
        frame(3, 2, 1, 0);
        check("R4 flush", flush_flag_o, 1);
        check("R4 freq", flush_req_o, 1);
        check("R2 no err", err_flag_o, 0);
        @(negedge clk);
        check("R4 freq single", flush_req_o, 0);
        check("R4 flag holds", flush_flag_o, 1);
    endtask

    task automatic t_both();
        ntrans_i = 2; clear_flags();
        frame(1, 1, 1, 0);
        check("R2 both err", err_flag_o, 1);
        check("R4 both flush", flush_req_o, 1);
        check("R5 unf suppressed", underflow_o, 0);
    endtask

    task automatic t_no_sent();
        ntrans_i = 3; clear_flags();
        frame(0, 0, 0, 0);
        check("R3 err", err_flag_o, 0);
        check("R3 flush", flush_flag_o, 0);
        check("R3 unf", underflow_o, 0);
    endtask

    task automatic t_disabled();
        clear_flags();
        ntrans_i = 0;
        frame(0, 0, 1, 0);
        check("R6 ntrans0", err_flag_o | flush_flag_o, 0);
        ntrans_i = 3; feat_en_i = 0;
        frame(0, 0, 1, 0);
        check("R6 feat", err_flag_o | flush_flag_o, 0);
        feat_en_i = 1; ep_hbiso_in_i = 0;
        frame(0, 0, 1, 0);
        check("R6 ep", err_flag_o | flush_flag_o | underflow_o, 0);
        ep_hbiso_in_i = 1;
    endtask

    task automatic t_sticky();
        ntrans_i = 3; clear_flags();
        frame(2, 3, 1, 0);
        frame(3, 3, 1, 0);
        check("R8 sticky", err_flag_o, 1);
        clear_flags();
        check("R8 cleared", err_flag_o, 0);
        // set and clear in the same cycle: set wins
        frame(2, 3, 1, 0);
        clear_flags();
        for (int i = 0; i < 2; i++) begin @(negedge clk); bank_val_i = 1; @(negedge clk); bank_val_i = 0; end
        for (int i = 0; i < 3; i++) begin @(negedge clk); in_tok_i = 1; @(negedge clk); in_tok_i = 0; end
        @(negedge clk); pkt_sent_i = 1; @(negedge clk); pkt_sent_i = 0;
        @(negedge clk); sof_i = 1; err_clr_i = 1;
        @(negedge clk); sof_i = 0; err_clr_i = 0;
        check("R8 set wins", err_flag_o, 1);
    endtask

    task automatic t_irq();
        ntrans_i = 3; clear_flags();
        err_ie_i = 0; flush_ie_i = 0;
        frame(2, 3, 1, 0);
        check("R9 masked", irq_o, 0);
        err_ie_i = 1; #1;
        check("R9 err", irq_o, 1);
        clear_flags();
        check("R9 cleared", irq_o, 0);
        frame(3, 2, 1, 0);
        check("R9 flush masked", irq_o, 0);
        flush_ie_i = 1; #1;
        check("R9 flush", irq_o, 1);
        err_ie_i = 0; flush_ie_i = 0;
    endtask

    task automatic t_restart();
        ntrans_i = 3; clear_flags();
        frame(3, 3, 1, 0);
        frame(0, 3, 1, 0);
        check("R7 restart", err_flag_o, 1);
        clear_flags();
        frame(3, 3, 1, 1);   // boundary carries one bank and one token
        frame(2, 2, 1, 0);
        check("R7 carry err", err_flag_o, 0);
        check("R7 carry flush", flush_flag_o, 0);
    endtask

    task automatic t_sat();
        ntrans_i = 3; clear_flags();
        frame(5, 5, 2, 0);
        check("R10 err", err_flag_o, 0);
        check("R10 flush", flush_flag_o, 0);
        ntrans_i = 1;
        frame(1, 1, 1, 0);
        check("R10 n1", err_flag_o | flush_flag_o, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bank_short();
        t_tok_miss();
        t_both();
        t_no_sent();
        t_disabled();
        t_sticky();
        t_irq();
        t_restart();
        t_sat();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule